// File: doc/BRIEF.md
# Dithered Fine-Code Interpolator

This block gives an oscillator's fine-tuning input a resolution sixteen times finer than its integer steps. It holds a base code C and a fraction `alpha`. On every oscillator clock cycle it draws a pseudo-random number from 0 to 15 and presents either C or C+1 to the oscillator. Over any sixteen cycles the code C+1 appears in exactly `alpha` of them. The average code is therefore C + alpha/16, which places fifteen virtual operating points between two neighbouring physical codes.

The random numbers come from a four-bit shift-register sequence. This sequence is extended so that it also passes through zero, and so it visits every value from 0 to 15 once per period. A loop controller in a slower control clock domain writes new settings. It presents a code and a fraction with a one-cycle load strobe. A toggle handshake through two-flop synchronisers then carries the pair into the oscillator domain. A busy flag covers the whole transfer. Any load made while busy is high is dropped. The controller may move `alpha` after each phase comparison and leave C unchanged.

Top module: `dither_code_interp`

## Requirements
- R1: After reset `fine_code` is 0 and `ctl_busy` is 0.
- R2: The random source runs through all sixteen values 0..15 once in every 16 consecutive oscillator cycles. With alpha = 1, the cycles that carry C+1 are therefore exactly 16 cycles apart.
- R3: With settings held, in every 16 consecutive oscillator cycles `fine_code` equals C+1 in exactly `alpha` cycles and C in the rest. It never takes any other value. C+1 is chosen when the random value is below `alpha`.
- R4: When alpha = 0, `fine_code` equals C on every cycle.
- R5: When C = 63 (all ones), `fine_code` stays at 63 for every alpha. The upper code saturates and does not wrap to 0.
- R6: A load accepted on a control clock edge sets `ctl_busy` at that edge. `ctl_busy` clears only after the oscillator domain has taken up the new code and fraction. The settings in use change only when a transfer completes.
- R7: A load strobe given while `ctl_busy` is 1 is ignored. The transfer already in flight completes with its own values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator output clock; the code is chosen once per cycle |
| osc_rst_n | input | 1 | Asynchronous active-low reset, oscillator domain |
| ctl_clk | input | 1 | Control (loop) clock |
| ctl_rst_n | input | 1 | Asynchronous active-low reset, control domain |
| ctl_load | input | 1 | One-cycle strobe that offers a new code and fraction |
| ctl_code | input | 6 | Base fine code C to load |
| ctl_alpha | input | 4 | Fraction in sixteenths to load |
| ctl_busy | output | 1 | High while a setting is crossing into the oscillator domain |
| fine_code | output | 6 | Instantaneous fine code sent to the oscillator |

## Verification
The hardest case to reach from the ports is a second load that arrives while the first one is still crossing the synchronisers. The bench gives a second strobe with different values on the control cycle right after the first. It then counts the codes over a full sixteen-cycle window and confirms that only the first setting took effect. A second hard case is the exact spacing of the dither pattern. Counting the codes cannot show it. The bench therefore records the cycle positions of C+1 across three periods at alpha = 1 and checks that they are evenly spaced.

// File: rtl/dci_pkg.sv
package dci_pkg;

   localparam int MIN_RAND_W = 3;
   localparam int MAX_RAND_W = 8;

   // Feedback tap mask for a left-shifting maximal-length register of width w.
   // The top bit is always a tap, which the zero-state extension relies on.
   function automatic logic [7:0] lfsr_taps(input int w);
      case (w)
         3:       return 8'h06;
         4:       return 8'h0C;
         5:       return 8'h14;
         6:       return 8'h30;
         7:       return 8'h60;
         default: return 8'hB8;
      endcase
   endfunction

endpackage

// File: rtl/dci_sync.sv
module dci_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("dci_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dci_lfsr.sv
module dci_lfsr #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] rnd
);
   generate
      if (W < dci_pkg::MIN_RAND_W || W > dci_pkg::MAX_RAND_W) begin : g_bad
         $error("dci_lfsr: W out of supported range");
      end
   endgenerate

   localparam logic [W-1:0] TAPS = W'(dci_pkg::lfsr_taps(W));

   logic [W-1:0] state;
   logic         fb;
   logic         low_zero;

   // The zero-state extension flips the feedback when the lower bits are all
   // zero. The sequence then runs 100..0 -> 000..0 -> 000..1 and the period is 2**W.
   assign low_zero = (state[W-2:0] == '0);
   assign fb       = (^(state & TAPS)) ^ low_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= '0;
      else        state <= {state[W-2:0], fb};
   end

   assign rnd = state;

   // R2
   zero_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == '0) |=> (state == W'(1)));

   // R2
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != '0) |=> (state != $past(state)));
endmodule

// File: rtl/dci_xfer.sv
module dci_xfer #(
   parameter int CODE_W      = 6,
   parameter int FRAC_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int INIT_CODE   = 0
) (
   input  logic              ctl_clk,
   input  logic              ctl_rst_n,
   input  logic              ctl_load,
   input  logic [CODE_W-1:0] ctl_code,
   input  logic [FRAC_W-1:0] ctl_alpha,
   output logic              ctl_busy,
   input  logic              osc_clk,
   input  logic              osc_rst_n,
   output logic [CODE_W-1:0] act_code,
   output logic [FRAC_W-1:0] act_alpha
);
   localparam logic [CODE_W-1:0] INIT_C = CODE_W'(INIT_CODE);

   // control side
   logic              req_tgl;
   logic              ack_sync;
   logic [CODE_W-1:0] hold_code;
   logic [FRAC_W-1:0] hold_alpha;
   logic              take;

   assign ctl_busy = req_tgl ^ ack_sync;
   assign take     = ctl_load && !ctl_busy;

   always_ff @(posedge ctl_clk or negedge ctl_rst_n) begin
      if (!ctl_rst_n) begin
         req_tgl    <= 1'b0;
         hold_code  <= INIT_C;
         hold_alpha <= '0;
      end else if (take) begin
         req_tgl    <= ~req_tgl;
         hold_code  <= ctl_code;
         hold_alpha <= ctl_alpha;
      end
   end

   // oscillator side
   logic req_sync;
   logic seen_tgl;

   dci_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk(osc_clk), .rst_n(osc_rst_n), .d(req_tgl), .q(req_sync));

   always_ff @(posedge osc_clk or negedge osc_rst_n) begin
      if (!osc_rst_n) begin
         seen_tgl  <= 1'b0;
         act_code  <= INIT_C;
         act_alpha <= '0;
      end else if (req_sync != seen_tgl) begin
         seen_tgl  <= req_sync;
         act_code  <= hold_code;
         act_alpha <= hold_alpha;
      end
   end

   dci_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(ctl_clk), .rst_n(ctl_rst_n), .d(seen_tgl), .q(ack_sync));

   // R7
   hold_stable_chk: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
      ctl_busy |=> ($stable(hold_code) && $stable(hold_alpha)));

   // R6
   act_quiet_chk: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
      (req_sync == seen_tgl) |=> ($stable(act_code) && $stable(act_alpha)));
endmodule

// File: rtl/dci_select.sv
module dci_select #(
   parameter int CODE_W = 6,
   parameter int FRAC_W = 4
) (
   input  logic [CODE_W-1:0] code,
   input  logic [FRAC_W-1:0] alpha,
   input  logic [FRAC_W-1:0] rnd,
   output logic [CODE_W-1:0] fine
);
   logic [CODE_W-1:0] code_up;

   always_comb begin
      code_up = (code == '1) ? code : code + CODE_W'(1);
      fine    = (rnd >= alpha) ? code : code_up;
   end
endmodule

// File: rtl/dither_code_interp.sv
module dither_code_interp #(
   parameter int CODE_W      = 6,
   parameter int FRAC_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int INIT_CODE   = 0
) (
   input  logic              osc_clk,
   input  logic              osc_rst_n,
   input  logic              ctl_clk,
   input  logic              ctl_rst_n,
   input  logic              ctl_load,
   input  logic [CODE_W-1:0] ctl_code,
   input  logic [FRAC_W-1:0] ctl_alpha,
   output logic              ctl_busy,
   output logic [CODE_W-1:0] fine_code
);
   localparam logic [CODE_W-1:0] CODE_MAX = '1;

   generate
      if (CODE_W < 2) begin : g_bad_code
         $error("dither_code_interp: CODE_W must be at least 2");
      end
      if (INIT_CODE < 0 || INIT_CODE >= (1 << CODE_W)) begin : g_bad_init
         $error("dither_code_interp: INIT_CODE does not fit CODE_W");
      end
   endgenerate

   logic [CODE_W-1:0] act_code;
   logic [FRAC_W-1:0] act_alpha;
   logic [FRAC_W-1:0] rnd;

   dci_xfer #(
      .CODE_W(CODE_W), .FRAC_W(FRAC_W),
      .SYNC_STAGES(SYNC_STAGES), .INIT_CODE(INIT_CODE)
   ) u_xfer (
      .ctl_clk(ctl_clk), .ctl_rst_n(ctl_rst_n), .ctl_load(ctl_load),
      .ctl_code(ctl_code), .ctl_alpha(ctl_alpha), .ctl_busy(ctl_busy),
      .osc_clk(osc_clk), .osc_rst_n(osc_rst_n),
      .act_code(act_code), .act_alpha(act_alpha));

   dci_lfsr #(.W(FRAC_W)) u_lfsr (
      .clk(osc_clk), .rst_n(osc_rst_n), .rnd(rnd));

   dci_select #(.CODE_W(CODE_W), .FRAC_W(FRAC_W)) u_sel (
      .code(act_code), .alpha(act_alpha), .rnd(rnd), .fine(fine_code));

   // R3
   adjacent_chk: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
      (fine_code == act_code) || (fine_code == act_code + CODE_W'(1)));

   // R4
   zero_frac_chk: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
      (act_alpha == '0) |-> (fine_code == act_code));

   // R5
   top_sat_chk: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
      (act_code == CODE_MAX) |-> (fine_code == CODE_MAX));
endmodule

// File: tb/tb_dither_code_interp.sv
`timescale 1ns/1ps
module tb_dither_code_interp;
   logic       osc_clk = 1'b0;
   logic       ctl_clk = 1'b0;
   logic       osc_rst_n = 1'b0;
   logic       ctl_rst_n = 1'b0;
   logic       ctl_load = 1'b0;
   logic [5:0] ctl_code = '0;
   logic [3:0] ctl_alpha = '0;
   logic       ctl_busy;
   logic [5:0] fine_code;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 osc_clk = ~osc_clk;   // 125 MHz
   always #5 ctl_clk = ~ctl_clk;   // control clock

   dither_code_interp dut (
      .osc_clk(osc_clk), .osc_rst_n(osc_rst_n),
      .ctl_clk(ctl_clk), .ctl_rst_n(ctl_rst_n),
      .ctl_load(ctl_load), .ctl_code(ctl_code), .ctl_alpha(ctl_alpha),
      .ctl_busy(ctl_busy), .fine_code(fine_code));

   // code, alpha, expected cycles away from C in 16 (R3, R4, R5)
   localparam int NV = 10;
   localparam int VC [NV] = '{5, 5, 5, 0, 62, 63, 63, 40, 17, 33};
   localparam int VA [NV] = '{1, 8, 15, 7, 15, 9, 0, 0, 3, 12};
   localparam int VE [NV] = '{1, 8, 15, 7, 15, 0, 0, 0, 3, 12};

   function automatic int up_of(input int c);
      return (c == 63) ? 63 : c + 1;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic load(input int c, input int a);
      @(negedge ctl_clk);
      ctl_code  = 6'(c);
      ctl_alpha = 4'(a);
      ctl_load  = 1'b1;
      @(negedge ctl_clk);
      ctl_load  = 1'b0;
   endtask

   task automatic settle();
      while (ctl_busy) @(negedge ctl_clk);
      repeat (3) @(negedge osc_clk);
   endtask

   task automatic measure(input int c, output int n_up, output int n_bad);
      n_up = 0;
      n_bad = 0;
      for (int k = 0; k < 16; k++) begin
         @(negedge osc_clk);
         if (int'(fine_code) == c) ;
         else if (c != 63 && int'(fine_code) == up_of(c)) n_up++;
         else n_bad++;
      end
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
   end

   initial begin
      int up, bad;
      repeat (3) @(negedge ctl_clk);
      osc_rst_n = 1'b1;
      ctl_rst_n = 1'b1;
      @(negedge osc_clk);
      // R1 reset state
      check(fine_code == 6'd0, "R1 fine_code", fine_code, 0);
      check(ctl_busy == 1'b0, "R1 ctl_busy", ctl_busy, 0);

      // table of settings: R3 counts, R4 alpha zero, R5 saturation
      for (int i = 0; i < NV; i++) begin
         load(VC[i], VA[i]);
         settle();
         measure(VC[i], up, bad);
         check(up == VE[i] && bad == 0,
               (VC[i] == 63) ? "R5 saturate" : (VA[i] == 0) ? "R4 alpha0" : "R3 window",
               up * 100 + bad, VE[i] * 100);
      end

      // R6: busy rises with the accepted load
      @(negedge ctl_clk);
      ctl_code = 6'd22; ctl_alpha = 4'd6; ctl_load = 1'b1;
      @(negedge ctl_clk);
      ctl_load = 1'b0;
      check(ctl_busy == 1'b1, "R6 busy after load", ctl_busy, 1);
      settle();
      measure(22, up, bad);
      check(up == 6 && bad == 0, "R6 new setting in use", up * 100 + bad, 600);

      // R7: second load while busy is dropped
      @(negedge ctl_clk);
      ctl_code = 6'd10; ctl_alpha = 4'd5; ctl_load = 1'b1;
      @(negedge ctl_clk);
      ctl_code = 6'd20; ctl_alpha = 4'd9;
      @(negedge ctl_clk);
      ctl_load = 1'b0;
      settle();
      measure(10, up, bad);
      check(up == 5 && bad == 0, "R7 load while busy ignored", up * 100 + bad, 500);

      // R2: with alpha 1, C+1 recurs every 16 cycles
      load(30, 1);
      settle();
      begin
         int pos [3];
         int hits = 0;
         for (int k = 0; k < 48; k++) begin
            @(negedge osc_clk);
            if (fine_code == 6'd31) begin
               if (hits < 3) pos[hits] = k;
               hits++;
            end
         end
         check(hits == 3, "R2 hit count", hits, 3);
         if (hits == 3) begin
            check(pos[1] - pos[0] == 16, "R2 spacing a", pos[1] - pos[0], 16);
            check(pos[2] - pos[1] == 16, "R2 spacing b", pos[2] - pos[1], 16);
         end
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule